// File: doc/BRIEF.md
# Sample-Stream Ramp Injector and Sequence Checker

This block puts a known pattern into a streaming acquisition path so that data loss can be found. It sits right after a converter's sample source. A free-running ramp counter steps once for every valid sample that arrives. A select register decides whether each outgoing word carries the real sample or the current ramp value. The counter keeps stepping in both modes, so switching modes never leaves a gap in the ramp.

A separate sequence checker watches the far end of the processing chain. In a clean stream, every value must be exactly one more than the value before it, and the step from all-ones to zero counts as a correct step. The first value after reset or after a re-arm only seeds the expected value. After each break, the checker takes the received value plus one as its new expected value, so one dropped sample gives one error. It keeps a saturating error count and holds the expected and received values of the first break it saw.

Top module: `stream_ramp_probe`

## Requirements
- R1: After reset, `dst_valid` is 0, `chk_err` is 0, `chk_err_count` is 0, `chk_fail_seen` is 0 and the select register holds sample mode.
- R2: `dst_valid` is 1 in the cycle after each cycle with `src_valid` high, and 0 in the cycle after each cycle with `src_valid` low.
- R3: In sample mode (select register 0), each output word equals the `src_data` of its input beat.
- R4: In ramp mode (select register 1), each output word is the ramp counter, which is 0 for the first beat after reset and one higher for each later beat.
- R5: The ramp counter steps on every input beat in either mode and holds on cycles with `src_valid` low.
- R6: A write (`sel_we` high, `sel_ramp` giving 1 for ramp or 0 for sample) affects beats from the next cycle on. A beat in the same cycle as the write uses the previous setting.
- R7: The ramp counter wraps from all-ones to zero.
- R8: The first `chk_valid` value after reset or re-arm raises no error and sets the expected value to that value plus one.
- R9: A checked value that differs from the expected value raises `chk_err` for one cycle, one cycle after the beat, and increments the count. The expected value then becomes the received value plus one.
- R10: A received zero when the expected value has wrapped from all-ones to zero is not an error.
- R11: `chk_err_count` saturates at all-ones.
- R12: On the first mismatch, `chk_fail_seen` is set and `chk_first_exp` / `chk_first_got` hold the expected and received values. These stay unchanged until re-arm.
- R13: `chk_rearm` clears the count, `chk_fail_seen`, both held values and the seed state. A `chk_valid` beat in the same cycle as the re-arm is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the select register |
| sel_ramp | input | 1 | Value to write: 1 ramp, 0 sample |
| src_valid | input | 1 | Sample beat from the converter source |
| src_data | input | DATA_W | Sample value |
| dst_valid | output | 1 | Downstream beat |
| dst_data | output | DATA_W | Downstream word (sample or ramp) |
| chk_valid | input | 1 | Beat at the end of the chain |
| chk_data | input | DATA_W | Value at the end of the chain |
| chk_rearm | input | 1 | Restart the checker |
| chk_err | output | 1 | One-cycle pulse on a sequence break |
| chk_err_count | output | ERR_W | Saturating break count |
| chk_fail_seen | output | 1 | A break has been recorded |
| chk_first_exp | output | DATA_W | Expected value at the first break |
| chk_first_got | output | DATA_W | Received value at the first break |

## Verification
An injector output word appears one cycle after its input beat, counting the single output register. The checker's pulse, count and held values update one cycle after the checked beat. A select write changes the source of beats from the following cycle on. The bench drives inputs on the falling edge and samples outputs one nanosecond after the next rising edge, so each result is read in exactly the cycle it is due. Reference models in the bench update on the same beats to give the expected values.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic {
        SRC_SAMPLE = 1'b0,
        SRC_RAMP   = 1'b1
    } src_sel_e;

    typedef enum logic {
        CHK_SEED  = 1'b0,
        CHK_TRACK = 1'b1
    } chk_state_e;

    function automatic src_sel_e decode_sel(input logic ramp_bit);
        return ramp_bit ? SRC_RAMP : SRC_SAMPLE;
    endfunction

endpackage

// File: rtl/rp_ramp_counter.sv
module rp_ramp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + ONE;
    end

    assign cnt = cnt_q;

    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt)); // R5
    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> (cnt - $past(cnt)) == ONE); // R7
endmodule

// File: rtl/rp_injector.sv
module rp_injector
    import rp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  src_sel_e     sel,
    input  logic [W-1:0] ramp,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d.vld = in_valid;
        beat_d.dat = beat_q.dat;
        if (in_valid) begin
            beat_d.dat = (sel == SRC_RAMP) ? ramp : in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign out_valid = beat_q.vld;
    assign out_data  = beat_q.dat;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == SRC_SAMPLE) |=> out_data == $past(in_data)); // R3
    AST_RAMP_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == SRC_RAMP) |=> out_data == $past(ramp)); // R4
endmodule

// File: rtl/rp_seq_checker.sv
module rp_seq_checker
    import rp_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [W-1:0]     data,
    input  logic             rearm,
    output logic             err,
    output logic [CNT_W-1:0] err_count,
    output logic             fail_seen,
    output logic [W-1:0]     first_exp,
    output logic [W-1:0]     first_got
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [W-1:0]     ONE     = W'(1);

    typedef struct packed {
        logic         seen;
        logic [W-1:0] exp;
        logic [W-1:0] got;
    } miss_t;

    chk_state_e       state;
    logic [W-1:0]     expect_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    miss_t            miss_q;
    logic             mismatch;

    assign mismatch = valid && (state == CHK_TRACK) && (data != expect_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CHK_SEED;
            expect_q <= '0;
            err_q    <= 1'b0;
            cnt_q    <= '0;
            miss_q   <= '0;
        end else begin
            err_q <= 1'b0;
            if (rearm) begin
                state  <= CHK_SEED;
                cnt_q  <= '0;
                miss_q <= '0;
            end else if (valid) begin
                state    <= CHK_TRACK;
                expect_q <= data + ONE;
                if (mismatch) begin
                    err_q <= 1'b1;
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
                    if (!miss_q.seen) miss_q <= '{seen: 1'b1, exp: expect_q, got: data};
                end
            end
        end
    end

    assign err       = err_q;
    assign err_count = cnt_q;
    assign fail_seen = miss_q.seen;
    assign first_exp = miss_q.exp;
    assign first_got = miss_q.got;

    AST_SEED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == CHK_SEED) |=> !err); // R8
    AST_PULSE_INC: assert property (@(posedge clk) disable iff (rst)
        (err && $past(err_count) != CNT_MAX) |-> err_count == $past(err_count) + CNT_ONE); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !rearm |=> err_count >= $past(err_count)); // R11
    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fail_seen && !rearm) |=> ($stable(first_exp) && $stable(first_got) && fail_seen)); // R12
    AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (err_count == '0 && !fail_seen && !err)); // R13
endmodule

// File: rtl/stream_ramp_probe.sv
module stream_ramp_probe
    import rp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic              sel_ramp,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    input  logic              chk_valid,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_rearm,
    output logic              chk_err,
    output logic [ERR_W-1:0]  chk_err_count,
    output logic              chk_fail_seen,
    output logic [DATA_W-1:0] chk_first_exp,
    output logic [DATA_W-1:0] chk_first_got
);
    src_sel_e          sel_q;
    logic [DATA_W-1:0] ramp;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= SRC_SAMPLE;
        else if (sel_we) sel_q <= decode_sel(sel_ramp);
    end

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> sel_q == decode_sel($past(sel_ramp))); // R6
    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !sel_we |=> $stable(sel_q)); // R6

    rp_ramp_counter #(.W(DATA_W)) u_ramp (
        .clk (clk),
        .rst (rst),
        .adv (src_valid),
        .cnt (ramp)
    );

    rp_injector #(.W(DATA_W)) u_inject (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (src_valid),
        .in_data   (src_data),
        .sel       (sel_q),
        .ramp      (ramp),
        .out_valid (dst_valid),
        .out_data  (dst_data)
    );

    rp_seq_checker #(.W(DATA_W), .CNT_W(ERR_W)) u_check (
        .clk       (clk),
        .rst       (rst),
        .valid     (chk_valid),
        .data      (chk_data),
        .rearm     (chk_rearm),
        .err       (chk_err),
        .err_count (chk_err_count),
        .fail_seen (chk_fail_seen),
        .first_exp (chk_first_exp),
        .first_got (chk_first_got)
    );
endmodule

// File: tb/stream_ramp_probe_tb.sv
`timescale 1ns/1ps
module stream_ramp_probe_tb;
    localparam int DW = 8;
    localparam int EW = 4;
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_we = 1'b0, sel_ramp = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          dst_valid;
    logic [DW-1:0] dst_data;
    logic          chk_valid = 1'b0, chk_rearm = 1'b0;
    logic [DW-1:0] chk_data = '0;
    logic          chk_err, chk_fail_seen;
    logic [EW-1:0] chk_err_count;
    logic [DW-1:0] chk_first_exp, chk_first_got;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    stream_ramp_probe #(.DATA_W(DW), .ERR_W(EW)) u_dut (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_ramp(sel_ramp),
        .src_valid(src_valid), .src_data(src_data),
        .dst_valid(dst_valid), .dst_data(dst_data),
        .chk_valid(chk_valid), .chk_data(chk_data), .chk_rearm(chk_rearm),
        .chk_err(chk_err), .chk_err_count(chk_err_count),
        .chk_fail_seen(chk_fail_seen), .chk_first_exp(chk_first_exp),
        .chk_first_got(chk_first_got)
    );

    // reference models
    logic [DW-1:0] m_ramp = '0;
    logic          m_sel  = 1'b0;
    logic          m_seeded = 1'b0;
    logic [DW-1:0] m_exp = '0;
    logic [EW-1:0] m_cnt = '0;
    logic          m_seen = 1'b0;
    logic [DW-1:0] m_fexp = '0, m_fgot = '0;

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] inj_expect(input logic s, input logic [DW-1:0] d,
                                                 input logic [DW-1:0] r);
        return s ? r : d;
    endfunction

    task automatic inj_step(input string tag, input logic v, input logic [DW-1:0] d,
                            input logic we, input logic ws);
        logic [DW-1:0] e;
        e = inj_expect(m_sel, d, m_ramp);
        @(negedge clk);
        src_valid = v; src_data = d; sel_we = we; sel_ramp = ws;
        @(posedge clk); #1;
        check_eq(tag, "dst_valid", 32'(dst_valid), 32'(v));
        if (v) check_eq(tag, "dst_data", 32'(dst_data), 32'(e));
        if (v)  m_ramp = m_ramp + 1'b1;
        if (we) m_sel = ws;
    endtask

    task automatic chk_step(input string tag, input logic v, input logic [DW-1:0] d,
                            input logic ra);
        logic e_err;
        e_err = 1'b0;
        if (ra) begin
            m_seeded = 1'b0; m_cnt = '0; m_seen = 1'b0; m_fexp = '0; m_fgot = '0;
        end else if (v) begin
            if (m_seeded && d != m_exp) begin
                e_err = 1'b1;
                if (m_cnt != EMAX) m_cnt = m_cnt + 1'b1;
                if (!m_seen) begin m_seen = 1'b1; m_fexp = m_exp; m_fgot = d; end
            end
            m_exp = d + 1'b1;
            m_seeded = 1'b1;
        end
        @(negedge clk);
        chk_valid = v; chk_data = d; chk_rearm = ra;
        @(posedge clk); #1;
        check_eq(tag, "chk_err", 32'(chk_err), 32'(e_err));
        check_eq(tag, "chk_err_count", 32'(chk_err_count), 32'(m_cnt));
        check_eq(tag, "chk_fail_seen", 32'(chk_fail_seen), 32'(m_seen));
        check_eq(tag, "chk_first_exp", 32'(chk_first_exp), 32'(m_fexp));
        check_eq(tag, "chk_first_got", 32'(chk_first_got), 32'(m_fgot));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.5;
        // R1 reset state
        check_eq("R1", "dst_valid", 32'(dst_valid), 0);
        check_eq("R1", "chk_err", 32'(chk_err), 0);
        check_eq("R1", "chk_err_count", 32'(chk_err_count), 0);
        check_eq("R1", "chk_fail_seen", 32'(chk_fail_seen), 0);
        inj_step("R1", 1'b1, 8'h5A, 1'b0, 1'b0); // sample mode after reset

        // R4 directed ramp start: ramp already at 1 after one sample-mode beat (R5)
        inj_step("R6", 1'b1, 8'hC3, 1'b1, 1'b1);  // write same cycle: still sample
        inj_step("R4", 1'b1, 8'h11, 1'b0, 1'b0);  // ramp value 2
        inj_step("R5", 1'b0, 8'h22, 1'b0, 1'b0);  // idle, no step
        inj_step("R5", 1'b1, 8'h33, 1'b0, 1'b0);  // ramp value 3
        inj_step("R6", 1'b1, 8'h44, 1'b1, 1'b0);  // switch back; this beat ramp
        inj_step("R3", 1'b1, 8'h55, 1'b0, 1'b0);  // sample

        // R2 R3 R4 R5 R6 constrained random
        for (int i = 0; i < 600; i++) begin
            inj_step("R2", ($urandom % 4) != 0, 8'($urandom),
                     ($urandom % 8) == 0, 1'($urandom));
        end
        // R7 run ramp through a wrap
        inj_step("R7", 1'b0, 8'h00, 1'b1, 1'b1);
        for (int i = 0; i < 260; i++) inj_step("R7", 1'b1, 8'($urandom), 1'b0, 1'b0);

        // checker
        chk_step("R13", 1'b0, 8'h00, 1'b1);
        chk_step("R8", 1'b1, 8'h37, 1'b0);
        for (int i = 0; i < 10; i++) chk_step("R9", 1'b1, m_exp, 1'b0);
        chk_step("R9", 1'b1, m_exp + 8'd1, 1'b0);    // one drop
        for (int i = 0; i < 5; i++) chk_step("R9", 1'b1, m_exp, 1'b0);
        chk_step("R12", 1'b1, m_exp - 8'd1, 1'b0);   // repeat, first latch kept
        chk_step("R12", 1'b0, 8'h00, 1'b0);
        chk_step("R10", 1'b1, 8'hFE, 1'b0);
        chk_step("R10", 1'b1, 8'hFF, 1'b0);
        chk_step("R10", 1'b1, 8'h00, 1'b0);
        chk_step("R10", 1'b1, 8'h01, 1'b0);
        for (int i = 0; i < 20; i++) chk_step("R11", 1'b1, m_exp + 8'd3, 1'b0);
        chk_step("R13", 1'b1, 8'h90, 1'b1);          // beat dropped with re-arm
        chk_step("R13", 1'b1, 8'h20, 1'b0);          // seeds, no error
        chk_step("R13", 1'b1, 8'h21, 1'b0);
        for (int i = 0; i < 400; i++) begin
            v = (($urandom % 10) == 0) ? 8'($urandom) : m_exp;
            chk_step("R9", ($urandom % 5) != 0, v, ($urandom % 97) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule